// File: doc/BRIEF.md
# Multi-Source Event Fragment Collector

For every level-1 accept, this block gathers one serial fragment from each of 23 front-end sources. It checks that all of the fragments carry the same event number. It then streams a single event record as 16-bit words toward an optical serializer.

A trigger pulse arriving while the block is idle sends a one-cycle request to every enabled source in the same cycle. All sources are then deserialized in parallel. A source that never starts its frame is not waited on forever: after a timeout it is marked missing. A source whose event tag disagrees with source 0 is marked as mismatched. Both conditions are reported inside the record, and the block never stalls. Sources switched off in the enable register are skipped, and zeros take the place of their data.

Top module: `evt_frag_collector`

## Requirements
- R1: After reset, `src_req`, `out_valid`, `out_sop`, `out_eop` and `err_flag` are all low and `out_word` is zero.
- R2: A high `l1a` sampled while idle latches `cfg_src_en` and raises `src_req` for exactly one cycle, on the next edge, for the enabled sources only. `src_req` is never high unless `l1a` was high one cycle earlier.
- R3: A source frame starts at the first edge, one or more cycles after its request, where both `src_ready` and `src_data` are 1 (the start bit). The next 88 bits on `src_data` are taken MSB first in this order: 12-bit event tag, 12-bit bunch tag, 64 data bits.
- R4: The record is 100 consecutive valid words, in this order:
  - header 0xA1F0, flagged by `out_sop`;
  - event tag word;
  - bunch tag word;
  - 92 data words;
  - two missing-mask words;
  - two mismatch-mask words;
  - trailer 0xE0F0, flagged by `out_eop`.
- R5: The data words carry source 0 through source 22 in order, four words per source, with bits 63:48 of each source sent first.
- R6: An enabled source that shows no start bit within 4096 cycles of collection start sets its bit (bit i for source i) in the missing mask, and its data words are zero. Each 23-bit mask is sent as bits 22:16 zero-extended, then bits 15:0.
- R7: A received source other than source 0 whose event tag differs from the tag of a received source 0 sets its bit in the mismatch mask. Its data is still sent.
- R8: A disabled source gets no request, its data words are zero, and it sets no mask bit.
- R9: `err_flag` is high on the trailer word exactly when either mask is non-zero, and it is low on every other cycle.
- R10: `l1a` pulses during collection or emission are ignored: no request and no extra record follows.
- R11: The event and bunch tag words hold the tags of source 0, zero-extended. Both are zero when source 0 is disabled or missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1a | input | 1 | Level-1 accept pulse |
| cfg_src_en | input | 23 | Per-source enable register |
| src_ready | input | 23 | Per-source data-ready |
| src_data | input | 23 | Per-source serial data |
| src_req | output | 23 | Per-source data request pulse |
| out_word | output | 16 | Record word |
| out_valid | output | 1 | Record word valid |
| out_sop | output | 1 | First word of record |
| out_eop | output | 1 | Last word of record |
| err_flag | output | 1 | Missing or mismatched source in this record |

## Verification
The request appears one edge after `l1a` is sampled, and the earliest start bit is accepted one edge after that. The header leaves the block two edges after the last frame bit of the slowest source is sampled; if any source is missing, this happens after the 4096-cycle timeout instead. The 100 words then follow back to back. The bench drives inputs and samples outputs on falling edges. It checks the request on the first falling edge after the trigger edge, and it checks that the header lands exactly three falling edges after the last frame bit was driven. Record words are compared by position, and each position is tied to the requirement that defines it.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam logic [15:0] REC_HEADER  = 16'hA1F0;
   localparam logic [15:0] REC_TRAILER = 16'hE0F0;

   typedef enum logic [1:0] {
      COL_IDLE,
      COL_GATHER,
      COL_EMIT
   } col_state_t;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_WAIT,
      DS_SHIFT,
      DS_DONE,
      DS_MISS
   } ds_state_t;
endpackage

// File: rtl/src_deser.sv
module src_deser #(
   parameter int TAG_W  = 12,
   parameter int DATA_W = 64,
   localparam int FRM_W = 2*TAG_W + DATA_W,
   localparam int CNT_W = $clog2(FRM_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             clr,
   input  logic             timeout,
   input  logic             ser_rdy,
   input  logic             ser_dat,
   output logic             done,
   output logic             miss,
   output logic [FRM_W-1:0] frame
);
   import evt_pkg::*;

   ds_state_t        st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         st    <= DS_IDLE;
         cnt   <= '0;
         frame <= '0;
      end else begin
         case (st)
            DS_IDLE: begin
               if (arm) st <= DS_WAIT;
            end
            DS_WAIT: begin
               if (timeout) begin
                  st <= DS_MISS;
               end else if (ser_rdy && ser_dat) begin
                  st  <= DS_SHIFT;
                  cnt <= '0;
               end
            end
            DS_SHIFT: begin
               frame <= {frame[FRM_W-2:0], ser_dat};
               if (cnt == CNT_W'(FRM_W-1)) st <= DS_DONE;
               else cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign done = (st == DS_DONE);
   assign miss = (st == DS_MISS);
endmodule

// File: rtl/tag_match.sv
module tag_match #(
   parameter int N_SRC = 23,
   parameter int TAG_W = 12
) (
   input  logic [N_SRC*TAG_W-1:0] tags,
   input  logic [N_SRC-1:0]       got,
   output logic [N_SRC-1:0]       mism
);
   assign mism[0] = 1'b0;
   for (genvar i = 1; i < N_SRC; i++) begin : g_cmp
      assign mism[i] = got[i] && got[0] &&
                       (tags[i*TAG_W +: TAG_W] != tags[0 +: TAG_W]);
   end
endmodule

// File: rtl/rec_emitter.sv
module rec_emitter #(
   parameter int N_SRC  = 23,
   parameter int TAG_W  = 12,
   parameter int DATA_W = 64,
   parameter int WORD_W = 16,
   localparam int WPS   = DATA_W / WORD_W,
   localparam int MW    = (N_SRC + WORD_W - 1) / WORD_W,
   localparam int D0    = 3,
   localparam int MISS0 = D0 + N_SRC*WPS,
   localparam int MISM0 = MISS0 + MW,
   localparam int TRL   = MISM0 + MW,
   localparam int IDX_W = $clog2(TRL + 1)
) (
   input  logic [IDX_W-1:0]        idx,
   input  logic [TAG_W-1:0]        evt_tag,
   input  logic [TAG_W-1:0]        bc_tag,
   input  logic [N_SRC*DATA_W-1:0] data_flat,
   input  logic [N_SRC-1:0]        miss_mask,
   input  logic [N_SRC-1:0]        mism_mask,
   output logic [WORD_W-1:0]       word
);
   import evt_pkg::*;
   localparam int PADW = MW * WORD_W;

   logic [PADW-1:0] miss_pad, mism_pad;
   assign miss_pad = PADW'(miss_mask);
   assign mism_pad = PADW'(mism_mask);

   always_comb begin
      word = '0;
      if (idx == '0)                word = WORD_W'(REC_HEADER);
      if (idx == IDX_W'(1))         word = WORD_W'(evt_tag);
      if (idx == IDX_W'(2))         word = WORD_W'(bc_tag);
      if (idx == IDX_W'(TRL))       word = WORD_W'(REC_TRAILER);
      for (int s = 0; s < N_SRC; s++) begin
         for (int w = 0; w < WPS; w++) begin
            if (idx == IDX_W'(D0 + s*WPS + w))
               word = data_flat[s*DATA_W + DATA_W - 1 - w*WORD_W -: WORD_W];
         end
      end
      for (int m = 0; m < MW; m++) begin
         if (idx == IDX_W'(MISS0 + m)) word = miss_pad[(MW-1-m)*WORD_W +: WORD_W];
         if (idx == IDX_W'(MISM0 + m)) word = mism_pad[(MW-1-m)*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/evt_frag_collector.sv
module evt_frag_collector #(
   parameter int N_SRC   = 23,
   parameter int TAG_W   = 12,
   parameter int DATA_W  = 64,
   parameter int WORD_W  = 16,
   parameter int TIMEOUT = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l1a,
   input  logic [N_SRC-1:0]  cfg_src_en,
   input  logic [N_SRC-1:0]  src_ready,
   input  logic [N_SRC-1:0]  src_data,
   output logic [N_SRC-1:0]  src_req,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid,
   output logic              out_sop,
   output logic              out_eop,
   output logic              err_flag
);
   import evt_pkg::*;

   localparam int FRM_W = 2*TAG_W + DATA_W;
   localparam int WPS   = DATA_W / WORD_W;
   localparam int MW    = (N_SRC + WORD_W - 1) / WORD_W;
   localparam int TRL   = 3 + N_SRC*WPS + 2*MW;
   localparam int IDX_W = $clog2(TRL + 1);
   localparam int TMR_W = $clog2(TIMEOUT + 1);

   if (WORD_W < 16) begin : g_bad_word
      $error("WORD_W must hold the 16-bit header");
   end
   if (DATA_W % WORD_W != 0) begin : g_bad_split
      $error("DATA_W must be a multiple of WORD_W");
   end
   if (TAG_W > WORD_W) begin : g_bad_tag
      $error("TAG_W must fit in one word");
   end
   if (N_SRC < 2 || TIMEOUT < 2) begin : g_bad_cnt
      $error("N_SRC and TIMEOUT must be at least 2");
   end

   col_state_t              st;
   logic [TMR_W-1:0]        tmr;
   logic [IDX_W-1:0]        idx;
   logic [N_SRC-1:0]        en_q;
   logic [N_SRC-1:0]        done, miss, mism, fin;
   logic [N_SRC*TAG_W-1:0]  evt_tags;
   logic [N_SRC*DATA_W-1:0] data_flat;
   logic [TAG_W-1:0]        bc0;
   logic                    timeout, clr;
   logic [WORD_W-1:0]       word_nx;
   logic                    last;

   assign timeout = (st == COL_GATHER) && (tmr == TMR_W'(TIMEOUT-1));
   assign last    = (idx == IDX_W'(TRL));
   assign clr     = (st == COL_EMIT) && last;
   assign fin     = ~en_q | done | miss;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [FRM_W-1:0] frm;
      src_deser #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_deser (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm     (src_req[i]),
         .clr     (clr),
         .timeout (timeout),
         .ser_rdy (src_ready[i]),
         .ser_dat (src_data[i]),
         .done    (done[i]),
         .miss    (miss[i]),
         .frame   (frm)
      );
      assign evt_tags[i*TAG_W +: TAG_W]   = frm[FRM_W-1 -: TAG_W];
      assign data_flat[i*DATA_W +: DATA_W] = done[i] ? frm[DATA_W-1:0] : '0;
      if (i == 0) begin : g_ref
         assign bc0 = done[0] ? frm[FRM_W-1-TAG_W -: TAG_W] : '0;
      end
   end

   tag_match #(.N_SRC(N_SRC), .TAG_W(TAG_W)) u_match (
      .tags (evt_tags),
      .got  (done),
      .mism (mism)
   );

   rec_emitter #(.N_SRC(N_SRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_emit (
      .idx       (idx),
      .evt_tag   (done[0] ? evt_tags[TAG_W-1:0] : '0),
      .bc_tag    (bc0),
      .data_flat (data_flat),
      .miss_mask (miss),
      .mism_mask (mism),
      .word      (word_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= COL_IDLE;
         tmr       <= '0;
         idx       <= '0;
         en_q      <= '0;
         src_req   <= '0;
         out_word  <= '0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         src_req   <= '0;
         out_word  <= '0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         err_flag  <= 1'b0;
         case (st)
            COL_IDLE: begin
               if (l1a) begin
                  en_q    <= cfg_src_en;
                  src_req <= cfg_src_en;
                  tmr     <= '0;
                  st      <= COL_GATHER;
               end
            end
            COL_GATHER: begin
               if (tmr < TMR_W'(TIMEOUT)) tmr <= tmr + 1'b1;
               if (&fin) begin
                  idx <= '0;
                  st  <= COL_EMIT;
               end
            end
            COL_EMIT: begin
               out_valid <= 1'b1;
               out_word  <= word_nx;
               out_sop   <= (idx == '0);
               out_eop   <= last;
               err_flag  <= last && ((|miss) || (|mism));
               if (last) st <= COL_IDLE;
               else idx <= idx + 1'b1;
            end
            default: st <= COL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/evt_collector_chk.sv
module evt_collector_chk #(
   parameter int N_SRC  = 23,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l1a,
   input logic [N_SRC-1:0]  src_req,
   input logic [WORD_W-1:0] out_word,
   input logic              out_valid,
   input logic              out_sop,
   input logic              out_eop,
   input logic              err_flag
);
   import evt_pkg::*;

   // R2
   req_after_l1a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_req) |-> $past(l1a));
   // R2
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_req) |=> (src_req == '0));
   // R4
   hdr_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> (out_valid && out_word == WORD_W'(REC_HEADER)));
   // R4
   trl_on_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> (out_valid && out_word == WORD_W'(REC_TRAILER)));
   // R4
   contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_eop) |=> out_valid);
   // R9
   err_at_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> out_eop);
   // R10
   no_req_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (src_req == '0));
endmodule

bind evt_frag_collector evt_collector_chk #(.N_SRC(N_SRC), .WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .l1a       (l1a),
   .src_req   (src_req),
   .out_word  (out_word),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .err_flag  (err_flag)
);

// File: tb/evt_frag_collector_tb.sv
module evt_frag_collector_tb;
   localparam int NS  = 23;
   localparam int NW  = 100;
   localparam int TRL = 99;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l1a = 1'b0;
   logic [NS-1:0] cfg_src_en = '0;
   logic [NS-1:0] src_ready = '0;
   logic [NS-1:0] src_data = '0;
   logic [NS-1:0] src_req;
   logic [15:0]   out_word;
   logic          out_valid, out_sop, out_eop, err_flag;

   int tests = 0;
   int fails = 0;

   int          dly  [NS];
   logic [11:0] etag [NS];
   logic [11:0] btag [NS];
   logic [63:0] dat  [NS];
   logic [15:0] cap  [NW];
   logic        cap_sop [NW];
   logic        cap_eop [NW];
   logic        cap_err [NW];
   int          ncap;
   int          first_c;
   int          last_bit_c;

   always #5 clk = ~clk;

   evt_frag_collector u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .l1a        (l1a),
      .cfg_src_en (cfg_src_en),
      .src_ready  (src_ready),
      .src_data   (src_data),
      .src_req    (src_req),
      .out_word   (out_word),
      .out_valid  (out_valid),
      .out_sop    (out_sop),
      .out_eop    (out_eop),
      .err_flag   (err_flag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_sources(input int base_dly, input logic [11:0] ev, input logic [11:0] bc);
      for (int s = 0; s < NS; s++) begin
         dly[s]  = base_dly + (s * 7) % 13;
         etag[s] = ev;
         btag[s] = bc;
         dat[s]  = {16'(16'h1000 + s), 16'(16'hA500 ^ s*3), 16'(16'h5A00 + s*17), 16'(16'hC0DE ^ s)};
      end
   endtask

   // Pulses l1a, plays all sources, captures one record. extra adds l1a pulses while busy.
   task automatic run_event(input logic [NS-1:0] en, input bit extra);
      logic [88:0] frm;
      int c;
      int maxd;
      ncap = 0;
      first_c = -1;
      maxd = -1;
      for (int s = 0; s < NS; s++)
         if (en[s] && dly[s] >= 0 && dly[s] > maxd) maxd = dly[s];
      last_bit_c = 1 + maxd + 88;
      @(negedge clk);
      cfg_src_en = en;
      l1a = 1'b1;
      @(negedge clk);
      l1a = 1'b0;
      // R2: request for enabled sources on the first falling edge after the trigger edge
      chk(src_req == en, "R2", "request vector", 32'(src_req), 32'(en));
      c = 0;
      while (c < 6000) begin
         for (int s = 0; s < NS; s++) begin
            if (dly[s] >= 0 && c >= 1 + dly[s] && c < 1 + dly[s] + 89) begin
               frm = {1'b1, etag[s], btag[s], dat[s]};
               src_ready[s] = 1'b1;
               src_data[s]  = frm[88 - (c - 1 - dly[s])];
            end else begin
               src_ready[s] = 1'b0;
               src_data[s]  = 1'b0;
            end
         end
         if (extra) l1a = (c == 5) || (ncap == 10);
         if (c >= 1 && src_req != '0)
            chk(1'b0, "R10", "request while busy", 32'(src_req), 32'h0);
         if (out_valid) begin
            if (ncap == 0) first_c = c;
            if (ncap < NW) begin
               cap[ncap] = out_word;
               cap_sop[ncap] = out_sop;
               cap_eop[ncap] = out_eop;
               cap_err[ncap] = err_flag;
            end
            ncap++;
            if (out_eop) break;
         end
         @(negedge clk);
         c++;
      end
      l1a = 1'b0;
      src_ready = '0;
      src_data = '0;
      repeat (40) begin
         @(negedge clk);
         if (out_valid || src_req != '0)
            chk(1'b0, "R10", "activity after record", {out_valid, 23'(src_req)}, 32'h0);
      end
   endtask

   task automatic check_record(input logic [NS-1:0] en, input string tag);
      logic [NS-1:0] xmiss, xmism;
      logic [15:0]   exp [NW];
      bit            got0;
      int            bad;
      string         rq;
      xmiss = '0;
      xmism = '0;
      for (int s = 0; s < NS; s++) xmiss[s] = en[s] && dly[s] < 0;
      got0 = en[0] && !xmiss[0];
      for (int s = 1; s < NS; s++)
         xmism[s] = got0 && en[s] && !xmiss[s] && etag[s] != etag[0];
      exp[0] = 16'hA1F0;
      exp[1] = got0 ? 16'(etag[0]) : 16'h0;
      exp[2] = got0 ? 16'(btag[0]) : 16'h0;
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < 4; w++)
            exp[3 + s*4 + w] = (en[s] && !xmiss[s]) ? 16'(dat[s] >> (48 - 16*w)) : 16'h0;
      exp[95] = 16'(xmiss >> 16);
      exp[96] = xmiss[15:0];
      exp[97] = 16'(xmism >> 16);
      exp[98] = xmism[15:0];
      exp[99] = 16'hE0F0;
      chk(ncap == NW, "R4", {tag, " word count"}, 32'(ncap), 32'(NW));
      if (ncap != NW) return;
      bad = 0;
      for (int k = 0; k < NW; k++) begin
         if (k == 0 || k == TRL) rq = "R4";
         else if (k < 3) rq = "R11";
         else if (k < 95) rq = !en[(k-3)/4] ? "R8" : (xmiss[(k-3)/4] ? "R6" : "R5");
         else if (k < 97) rq = "R6";
         else rq = "R7";
         if (cap[k] != exp[k]) begin
            bad++;
            chk(1'b0, rq, $sformatf("%s word %0d", tag, k), 32'(cap[k]), 32'(exp[k]));
         end
      end
      chk(bad == 0, "R5", {tag, " record contents"}, 32'(bad), 32'h0);
      chk(cap_sop[0] && cap_eop[TRL], "R4", {tag, " frame markers"},
          {cap_sop[0], cap_eop[TRL]}, 32'h3);
      // R9: error flag only on the trailer, set when either mask is non-zero
      bad = 0;
      for (int k = 0; k < TRL; k++) if (cap_err[k]) bad++;
      chk(bad == 0 && cap_err[TRL] == ((xmiss | xmism) != '0), "R9", {tag, " error flag"},
          {bad[15:0], 15'h0, cap_err[TRL]}, 32'((xmiss | xmism) != '0));
   endtask

   task automatic t_reset;
      // R1
      chk(src_req == '0 && !out_valid && !out_sop && !out_eop && !err_flag && out_word == '0,
          "R1", "reset outputs", {out_valid, out_sop, out_eop, err_flag, 12'h0, out_word}, 32'h0);
   endtask

   task automatic t_all_good;
      // R3 R5 R11: all sources answer with staggered delays and matching tags
      set_sources(0, 12'h3C5, 12'hABC);
      run_event('1, 1'b0);
      check_record('1, "all-good");
      // R3: header three falling edges after the last frame bit was driven
      chk(first_c == last_bit_c + 3, "R3", "header latency", 32'(first_c), 32'(last_bit_c + 3));
   endtask

   task automatic t_missing;
      // R6: sources 5 and 22 never answer
      set_sources(2, 12'h111, 12'h222);
      dly[5] = -1;
      dly[22] = -1;
      run_event('1, 1'b0);
      check_record('1, "missing");
   endtask

   task automatic t_mismatch;
      // R7: source 7 and source 16 report a different event tag
      set_sources(1, 12'h7E1, 12'h00F);
      etag[7] = 12'h7E2;
      etag[16] = 12'h000;
      run_event('1, 1'b0);
      check_record('1, "mismatch");
   endtask

   task automatic t_disabled;
      logic [NS-1:0] en;
      // R8 R11: source 0 and source 3 disabled, source 9 carries another tag (no reference)
      set_sources(0, 12'h456, 12'h789);
      etag[9] = 12'hFFF;
      en = '1;
      en[0] = 1'b0;
      en[3] = 1'b0;
      run_event(en, 1'b0);
      check_record(en, "disabled");
   endtask

   task automatic t_busy_l1a;
      // R10: extra triggers during gathering and emission
      set_sources(3, 12'h0A0, 12'h0B0);
      run_event('1, 1'b1);
      check_record('1, "busy-l1a");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_all_good();
      t_missing();
      t_mismatch();
      t_disabled();
      t_busy_l1a();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule